// File: doc/BRIEF.md
# Pulse-Link to SPI Slave Bridge

This block sits at the far end of a two-wire pulse link and acts as the SPI master for one local SPI slave. The link receiver hands it decoded symbols. There are two long symbols that frame a transaction and two short symbols that each carry one data bit. The block turns each symbol into the matching transitions on the slave's chip select, clock and data-in lines. It also samples the slave's data-out line and answers every bit with a reply strobe. The strobe is raised only when the sampled level is 0, so a level of 1 leaves the link undriven.

Each data bit runs as a self-timed sequence: set MOSI, hold it for a setup interval, pulse SCK away from its resting level, then wait a response interval and sample MISO. There are two sets of interval lengths, one fast and one slow, and each length is a parameter in system-clock cycles. The SLOW input picks the set when chip select falls. Clock polarity (POL) and clock phase (PHA) are latched at the same moment. When PHA is 1, SCK rests at its active level for the whole transaction. Each data pulse then makes the latching edge back to idle first, followed by the shifting edge.

Symbol codes on `sym_code_i`: 0 = long negative (open), 1 = long positive (close), 2 = short positive (data 1), 3 = short negative (data 0).

Top module: `pulse_spi_bridge`

## Requirements
- R1: During and after reset: `spi_cs_no` is 1, `spi_mosi_o` is 0, `reply_neg_o` is 0, and `spi_sck_o` equals `cfg_pol_i`.
- R2: A code 0 symbol drives `spi_cs_no` low from the next cycle and latches POL, PHA and SLOW. For the rest of the transaction, SCK rests at `!pol` if PHA=1 and at `pol` if PHA=0. Later changes to POL or PHA have no effect until the next code 0.
- R3: Let R be the response length of the latched profile. After code 0 is taken at edge k, MISO is sampled at edge k+R. `reply_neg_o` is high for exactly the one following cycle if the sample was 0, and stays low if it was 1.
- R4: A data symbol (code 2 = 1, code 3 = 0) taken at edge k sets `spi_mosi_o` from the next cycle. SCK holds its resting level for S cycles, is inverted for P cycles, and then returns to rest. S is the setup length and P the pulse length. MOSI does not change during the sequence.
- R5: Every data symbol is answered in the same way as R3, with MISO sampled at edge k+S+P+R.
- R6: The profile (fast or slow) is taken from `cfg_slow_i` when CS falls. Changing `cfg_slow_i` during the transaction does not change any interval.
- R7: A code 1 symbol drives `spi_cs_no` high from the next cycle and returns SCK to `cfg_pol_i`. It also aborts any running sequence, so no pulse or reply follows.
- R8: Data symbols are ignored while CS is high or while a bit sequence is still running. CS, SCK, MOSI and the reply all stay as they were.
- R9: A code 0 symbol while CS is already low restarts the transaction as in R2 and R3. Any running sequence is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sym_valid_i | input | 1 | One-cycle strobe: a validated link symbol is present |
| sym_code_i | input | 2 | Symbol code (0 open, 1 close, 2 data 1, 3 data 0) |
| cfg_pol_i | input | 1 | SCK idle level |
| cfg_pha_i | input | 1 | Clock phase: 1 = latch on second edge |
| cfg_slow_i | input | 1 | Select the slow interval profile |
| spi_miso_i | input | 1 | Data out from the SPI slave |
| spi_cs_no | output | 1 | Active-low chip select to the slave |
| spi_sck_o | output | 1 | SPI clock to the slave |
| spi_mosi_o | output | 1 | Data in to the slave |
| reply_neg_o | output | 1 | One-cycle request to send a short negative symbol |

## Verification
The hardest situations to reach are a symbol that arrives in the middle of a running bit sequence and a configuration change made after CS has fallen. Both depend on symbol timing that a well-behaved link master never produces. The stimulus therefore injects a conflicting data symbol one cycle into a setup interval. It also drops a close or open symbol two cycles into a bit, and flips SLOW and POL right after the opening symbol. Each time, it checks SCK, MOSI and the reply on every cycle against the profile that was latched. Random transactions with mixed POL, PHA, SLOW, bit counts and MISO levels cover the normal flow.

// File: rtl/pulse_spi_bridge_pkg.sv
package pulse_spi_bridge_pkg;

  typedef enum logic [1:0] {
    SYM_OPEN  = 2'd0,
    SYM_CLOSE = 2'd1,
    SYM_ONE   = 2'd2,
    SYM_ZERO  = 2'd3
  } sym_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READY,
    ST_SETUP,
    ST_PULSE,
    ST_RESP
  } state_e;

  typedef enum logic [1:0] {
    PH_SETUP,
    PH_PULSE,
    PH_RESP
  } phase_e;

endpackage

// File: rtl/psb_sym_decode.sv
module psb_sym_decode
  import pulse_spi_bridge_pkg::*;
(
  input  logic       valid_i,
  input  logic [1:0] code_i,
  output logic       open_o,
  output logic       close_o,
  output logic       data_o,
  output logic       bit_o
);

  always_comb begin
    open_o  = valid_i && (code_i == SYM_OPEN);
    close_o = valid_i && (code_i == SYM_CLOSE);
    data_o  = valid_i && ((code_i == SYM_ONE) || (code_i == SYM_ZERO));
    bit_o   = (code_i == SYM_ONE);
  end

endmodule

// File: rtl/psb_interval_timer.sv
module psb_interval_timer #(
  parameter int unsigned CW      = 6,
  parameter int unsigned MAX_CYC = 47
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_m1_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= len_m1_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // counter never exceeds the longest interval (R4, R5)
  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) < MAX_CYC);

  a_r5_cnt_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/pulse_spi_bridge.sv
module pulse_spi_bridge
  import pulse_spi_bridge_pkg::*;
#(
  parameter int unsigned FAST_SETUP_CYC = 5,
  parameter int unsigned FAST_PULSE_CYC = 5,
  parameter int unsigned FAST_RESP_CYC  = 5,
  parameter int unsigned SLOW_SETUP_CYC = 45,
  parameter int unsigned SLOW_PULSE_CYC = 45,
  parameter int unsigned SLOW_RESP_CYC  = 45
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sym_valid_i,
  input  logic [1:0] sym_code_i,
  input  logic       cfg_pol_i,
  input  logic       cfg_pha_i,
  input  logic       cfg_slow_i,
  input  logic       spi_miso_i,
  output logic       spi_cs_no,
  output logic       spi_sck_o,
  output logic       spi_mosi_o,
  output logic       reply_neg_o
);

  localparam int unsigned MAX_F   = (FAST_SETUP_CYC > FAST_PULSE_CYC) ?
                                    ((FAST_SETUP_CYC > FAST_RESP_CYC) ? FAST_SETUP_CYC : FAST_RESP_CYC) :
                                    ((FAST_PULSE_CYC > FAST_RESP_CYC) ? FAST_PULSE_CYC : FAST_RESP_CYC);
  localparam int unsigned MAX_S   = (SLOW_SETUP_CYC > SLOW_PULSE_CYC) ?
                                    ((SLOW_SETUP_CYC > SLOW_RESP_CYC) ? SLOW_SETUP_CYC : SLOW_RESP_CYC) :
                                    ((SLOW_PULSE_CYC > SLOW_RESP_CYC) ? SLOW_PULSE_CYC : SLOW_RESP_CYC);
  localparam int unsigned MAX_CYC = (MAX_F > MAX_S) ? MAX_F : MAX_S;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  function automatic logic [CW-1:0] len_m1(input phase_e ph, input logic slow);
    int unsigned n;
    case (ph)
      PH_SETUP: n = slow ? SLOW_SETUP_CYC : FAST_SETUP_CYC;
      PH_PULSE: n = slow ? SLOW_PULSE_CYC : FAST_PULSE_CYC;
      default:  n = slow ? SLOW_RESP_CYC  : FAST_RESP_CYC;
    endcase
    return CW'(n - 1);
  endfunction

  logic sym_open, sym_close, sym_data, sym_bit;
  logic tmr_load, tmr_done;
  logic [CW-1:0] tmr_len;

  state_e state_q, state_d;
  logic cs_n_q, cs_n_d;
  logic mosi_q, mosi_d;
  logic pulse_q, pulse_d;
  logic reply_q, reply_d;
  logic pol_q, pha_q, slow_q;

  psb_sym_decode u_dec (
    .valid_i (sym_valid_i),
    .code_i  (sym_code_i),
    .open_o  (sym_open),
    .close_o (sym_close),
    .data_o  (sym_data),
    .bit_o   (sym_bit)
  );

  psb_interval_timer #(.CW(CW), .MAX_CYC(MAX_CYC)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .len_m1_i (tmr_len),
    .done_o   (tmr_done)
  );

  always_comb begin
    state_d  = state_q;
    cs_n_d   = cs_n_q;
    mosi_d   = mosi_q;
    pulse_d  = pulse_q;
    reply_d  = 1'b0;
    tmr_load = 1'b0;
    tmr_len  = '0;
    if (sym_open) begin
      // open or restart: profile comes from the live SLOW input
      state_d  = ST_RESP;
      cs_n_d   = 1'b0;
      pulse_d  = 1'b0;
      tmr_load = 1'b1;
      tmr_len  = len_m1(PH_RESP, cfg_slow_i);
    end else if (sym_close) begin
      state_d = ST_IDLE;
      cs_n_d  = 1'b1;
      pulse_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_READY: if (sym_data) begin
          state_d  = ST_SETUP;
          mosi_d   = sym_bit;
          tmr_load = 1'b1;
          tmr_len  = len_m1(PH_SETUP, slow_q);
        end
        ST_SETUP: if (tmr_done) begin
          state_d  = ST_PULSE;
          pulse_d  = 1'b1;
          tmr_load = 1'b1;
          tmr_len  = len_m1(PH_PULSE, slow_q);
        end
        ST_PULSE: if (tmr_done) begin
          state_d  = ST_RESP;
          pulse_d  = 1'b0;
          tmr_load = 1'b1;
          tmr_len  = len_m1(PH_RESP, slow_q);
        end
        ST_RESP: if (tmr_done) begin
          state_d = ST_READY;
          reply_d = !spi_miso_i;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      mosi_q  <= 1'b0;
      pulse_q <= 1'b0;
      reply_q <= 1'b0;
      pol_q   <= 1'b0;
      pha_q   <= 1'b0;
      slow_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_n_q  <= cs_n_d;
      mosi_q  <= mosi_d;
      pulse_q <= pulse_d;
      reply_q <= reply_d;
      if (sym_open) begin
        pol_q  <= cfg_pol_i;
        pha_q  <= cfg_pha_i;
        slow_q <= cfg_slow_i;
      end
    end
  end

  // resting level while selected; PHA=1 parks SCK at the active level
  assign spi_sck_o   = cs_n_q ? cfg_pol_i : ((pha_q ? !pol_q : pol_q) ^ pulse_q);
  assign spi_cs_no   = cs_n_q;
  assign spi_mosi_o  = mosi_q;
  assign reply_neg_o = reply_q;

  a_r2_open_selects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_open |=> (!spi_cs_no &&
                  spi_sck_o == ($past(cfg_pha_i) ? !$past(cfg_pol_i) : $past(cfg_pol_i))));

  a_r3_reply_only_on_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reply_neg_o |-> ($past(!spi_miso_i) && !spi_cs_no));

  a_r4_mosi_changes_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(spi_mosi_o) |-> (state_q == ST_SETUP));

  a_r7_close_deselects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_close |=> (spi_cs_no && !reply_neg_o));

  a_r8_idle_no_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !reply_neg_o);

endmodule

// File: tb/pulse_spi_bridge_tb_top.sv
module pulse_spi_bridge_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int FS = 3, FP = 4, FR = 5;
  localparam int SS = 20, SP = 22, SR = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_valid = 1'b0;
  logic [1:0] sym_code = 2'd0;
  logic cfg_pol = 1'b0, cfg_pha = 1'b0, cfg_slow = 1'b0, miso = 1'b1;
  logic cs_n, sck, mosi, reply;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit m_pol, m_pha, m_slow;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_spi_bridge #(
    .FAST_SETUP_CYC(FS), .FAST_PULSE_CYC(FP), .FAST_RESP_CYC(FR),
    .SLOW_SETUP_CYC(SS), .SLOW_PULSE_CYC(SP), .SLOW_RESP_CYC(SR)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sym_valid_i(sym_valid), .sym_code_i(sym_code),
    .cfg_pol_i(cfg_pol), .cfg_pha_i(cfg_pha), .cfg_slow_i(cfg_slow), .spi_miso_i(miso),
    .spi_cs_no(cs_n), .spi_sck_o(sck), .spi_mosi_o(mosi), .reply_neg_o(reply)
  );

  function automatic int t_len(int ph, bit slow);
    case (ph)
      0: return slow ? SS : FS;
      1: return slow ? SP : FP;
      default: return slow ? SR : FR;
    endcase
  endfunction

  function automatic bit rest_lvl(bit pol, bit pha);
    return pha ? !pol : pol;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive_sym(input logic [1:0] code);
    @(negedge clk);
    sym_valid = 1'b1;
    sym_code  = code;
    @(negedge clk);
    sym_valid = 1'b0;
  endtask

  // R2/R3/R9: open (or restart) and first reply
  task automatic open_txn(input bit pol, input bit pha, input bit slow, input bit m);
    int r;
    @(negedge clk);
    cfg_pol = pol; cfg_pha = pha; cfg_slow = slow; miso = m;
    sym_valid = 1'b1; sym_code = 2'd0;
    @(negedge clk);
    sym_valid = 1'b0;
    m_pol = pol; m_pha = pha; m_slow = slow;
    r = t_len(2, slow);
    for (int i = 0; i <= r; i++) begin
      if (i > 0) @(negedge clk);
      chk("R2 cs low", cs_n, 1'b0);
      chk("R2 sck rest", sck, rest_lvl(m_pol, m_pha));
      chk("R3 first reply", reply, (i == r) ? !m : 1'b0);
    end
  endtask

  // R4/R5 (and R8 when inject is set)
  task automatic send_bit(input bit b, input bit m, input bit inject);
    int s, p, r;
    s = t_len(0, m_slow); p = t_len(1, m_slow); r = t_len(2, m_slow);
    @(negedge clk);
    miso = m; sym_valid = 1'b1; sym_code = b ? 2'd2 : 2'd3;
    @(negedge clk);
    sym_valid = 1'b0;
    for (int i = 0; i <= s + p + r; i++) begin
      if (i > 0) @(negedge clk);
      if (inject && i == 0) begin sym_valid = 1'b1; sym_code = b ? 2'd3 : 2'd2; end
      if (inject && i == 1) sym_valid = 1'b0;
      chk(inject ? "R8 busy mosi" : "R4 mosi", mosi, b);
      chk("R4 sck", sck, (i >= s && i < s + p) ? !rest_lvl(m_pol, m_pha) : rest_lvl(m_pol, m_pha));
      chk("R5 reply", reply, (i == s + p + r) ? !m : 1'b0);
    end
  endtask

  // R7: close, then quiet
  task automatic close_txn();
    drive_sym(2'd1);
    for (int i = 0; i < 4; i++) begin
      if (i > 0) @(negedge clk);
      chk("R7 cs high", cs_n, 1'b1);
      chk("R7 sck idle", sck, cfg_pol);
      chk("R7 no reply", reply, 1'b0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    bit last_mosi;
    void'($urandom(32'd2718));
    // R1 reset state
    #(CLK_PERIOD * 3 + 1);
    chk("R1 cs", cs_n, 1'b1);
    chk("R1 sck", sck, 1'b0);
    chk("R1 mosi", mosi, 1'b0);
    chk("R1 reply", reply, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cs after", cs_n, 1'b1);
    chk("R1 reply after", reply, 1'b0);

    // R8: data while deselected is ignored
    cfg_pol = 1'b1;
    miso = 1'b0;
    drive_sym(2'd2);
    for (int i = 0; i < FS + FP + FR + 3; i++) begin
      if (i > 0) @(negedge clk);
      chk("R8 cs", cs_n, 1'b1);
      chk("R8 sck", sck, 1'b1);
      chk("R8 mosi", mosi, 1'b0);
      chk("R8 reply", reply, 1'b0);
    end

    // mode 0, fast, busy injection
    open_txn(1'b0, 1'b0, 1'b0, 1'b0);
    send_bit(1'b1, 1'b1, 1'b0);
    send_bit(1'b0, 1'b0, 1'b1);
    send_bit(1'b1, 1'b0, 1'b0);
    close_txn();

    // R6/R2: slow mode 3, then config flipped mid-transaction
    open_txn(1'b1, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    cfg_slow = 1'b0; cfg_pol = 1'b0; cfg_pha = 1'b0;
    send_bit(1'b0, 1'b0, 1'b0);
    send_bit(1'b1, 1'b1, 1'b0);
    close_txn();

    // R9: restart while selected, and mid-sequence
    open_txn(1'b0, 1'b1, 1'b0, 1'b1);
    send_bit(1'b1, 1'b0, 1'b0);
    open_txn(1'b1, 1'b0, 1'b0, 1'b0);
    send_bit(1'b0, 1'b1, 1'b0);
    drive_sym(2'd2);
    @(negedge clk);
    open_txn(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 mosi kept", mosi, 1'b1);
    send_bit(1'b0, 1'b0, 1'b0);

    // R7: close during a running bit aborts it
    drive_sym(2'd2);
    @(negedge clk);
    drive_sym(2'd1);
    last_mosi = mosi;
    for (int i = 0; i < FS + FP + FR + 4; i++) begin
      if (i > 0) @(negedge clk);
      chk("R7 abort cs", cs_n, 1'b1);
      chk("R7 abort sck", sck, cfg_pol);
      chk("R7 abort reply", reply, 1'b0);
      chk("R7 abort mosi", mosi, last_mosi);
    end

    // random transactions
    for (int t = 0; t < 30; t++) begin
      int nb;
      open_txn(1'($urandom), 1'($urandom), ($urandom % 4) == 0, 1'($urandom));
      if ($urandom % 2) cfg_slow = !cfg_slow;
      nb = 1 + int'($urandom % 6);
      for (int k = 0; k < nb; k++)
        send_bit(1'($urandom), 1'($urandom), ($urandom % 5) == 0);
      close_txn();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule